// File: doc/BRIEF.md
# Serial DDS Settings Receiver

This block sits on the device side of a frequency synthesizer and receives its settings over a three-wire serial link. The three wires are a data line, a bit clock and an update strobe. On each rising edge of the bit clock, one bit enters a 40-bit staging shift register, least significant bit first. A rising edge on the update strobe copies the staged word into a separate active register. The active register drives the synthesizer core with a 32-bit tuning word, a 5-bit phase offset, a reference-multiplier enable and a power-down flag.

All three serial wires are asynchronous to the system clock. Each wire passes through a two-flop synchronizer, and its rising edges are detected in the system clock domain. Because the settings are double-buffered, the shifted bits never disturb the synthesizer until a strobe arrives. The staging register keeps accepting bits while the power-down flag is set.

The serial side has no ready signal, so the block cannot apply back-pressure. A bit is taken on every detected bit-clock edge, and the sender must keep each bit-clock level and each strobe level for at least three system clock cycles. The settings and the two error flags are plain level outputs.

Top module: `dds_cfg_rx`

## Requirements
- R1: After reset, the tuning word, phase, multiplier enable, power-down, frame error and reserved-bit error outputs are all 0.
- R2: On each synchronized rising edge of `bclk_i`, the staging register shifts by one place. The new bit from `sdata_i` enters at position 39, and every other bit moves down one position, so after 40 edges the first bit sent sits at position 0.
- R3: The positions of the staged word map to the outputs as follows: bit 32 drives `mult_en_o`, bits 35..39 drive `phase_o` (LSB at bit 35), bits 0..31 drive `freq_o` (LSB at bit 0), and bit 34 drives `pwr_down_o`. Bit 33 is reserved and must be 0.
- R4: Shifting bits in leaves every output unchanged until the next strobe.
- R5: A rising edge of `upd_i` with bit 33 clear copies the staged word into the active settings.
- R6: The staging register accepts new bits while `pwr_down_o` is 1. A strobe of a word with bit 34 set enters power-down, and a later strobe of a word with bit 34 clear leaves it.
- R7: Every strobe resets the bit count. If the count at the strobe is not exactly 40, `frame_err_o` is set to 1 and the word is still transferred. A strobe with no bits shifted since the last strobe therefore reports a frame error.
- R8: If a strobe finds bit 33 set to 1, `rsvd_err_o` is set to 1 and the active settings keep their previous values.
- R9: Both error flags reflect only the most recent strobe, so a strobe of a clean 40-bit word clears them.
- R10: If more than 40 bits arrive before a strobe, the last 40 bits are kept in order and the frame error is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sdata_i | input | 1 | Serial data, asynchronous |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| upd_i | input | 1 | Update strobe, asynchronous |
| freq_o | output | 32 | Active tuning word |
| phase_o | output | 5 | Active phase offset |
| mult_en_o | output | 1 | Active reference-multiplier enable |
| pwr_down_o | output | 1 | Active power-down flag |
| frame_err_o | output | 1 | Last strobe saw a bit count other than 40 |
| rsvd_err_o | output | 1 | Last strobe saw reserved bit 33 set |

## Verification
The bench drives a word whose reserved bit is set. A design that still loaded that word would show a changed tuning word after the strobe. The bench also sends a short frame and an overlong frame. A design that wrongly dropped short frames, rejected extra bits or lost bit order would show a mismatch in the transferred fields. Other cases are a strobe repeated with no new bits, which catches a counter that is not cleared on each strobe, and a word shifted in during power-down, which catches a staging register that is gated by the power-down flag. Outputs are also sampled between shifting and strobing, which catches any leak from the staging register to the outputs.

// File: rtl/dds_rx_pkg.sv
package dds_rx_pkg;
  localparam int WORD_BITS  = 40;
  localparam int FREQ_BITS  = 32;
  localparam int PHASE_BITS = 5;
  localparam int MULT_POS   = 32;
  localparam int RSVD_POS   = 33;
  localparam int PD_POS     = 34;
  localparam int PHASE_LSB  = 35;
  localparam int CNT_W      = $clog2(WORD_BITS + 2);

  typedef struct packed {
    logic [FREQ_BITS-1:0]  freq;
    logic [PHASE_BITS-1:0] phase;
    logic                  mult_en;
    logic                  pwr_down;
  } dds_cfg_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
  import dds_rx_pkg::*;
#(
  parameter int NBITS = WORD_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  input  logic             bclk_i,
  input  logic             clr_i,
  output logic [NBITS-1:0] word_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(NBITS + 1);

  logic bclk_prev_q;
  logic shift_en;

  assign shift_en = bclk_i & ~bclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_prev_q <= 1'b0;
      word_o      <= '0;
      cnt_o       <= '0;
    end else begin
      bclk_prev_q <= bclk_i;
      if (shift_en) word_o <= {bit_i, word_o[NBITS-1:1]};
      if (clr_i)
        cnt_o <= '0;
      else if (shift_en && cnt_o != CNT_SAT)
        cnt_o <= cnt_o + 1'b1;
    end
  end

  // R2: the detected bit-clock edge lasts a single cycle
  a_r2_single_shift: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> !shift_en);
  // R10: the bit count saturates and never wraps
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= CNT_SAT);
  // R7: the count restarts after each strobe
  a_r7_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !shift_en |=> cnt_o == '0);
endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
  import dds_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_i,
  input  logic [WORD_BITS-1:0] word_i,
  input  logic [CNT_W-1:0]     cnt_i,
  output logic                 upd_rise_o,
  output dds_cfg_t             cfg_o,
  output logic                 frame_err_o,
  output logic                 rsvd_err_o
);
  logic     upd_prev_q;
  dds_cfg_t decoded;

  assign upd_rise_o = upd_i & ~upd_prev_q;

  always_comb begin
    decoded.freq     = word_i[FREQ_BITS-1:0];
    decoded.phase    = word_i[PHASE_LSB +: PHASE_BITS];
    decoded.mult_en  = word_i[MULT_POS];
    decoded.pwr_down = word_i[PD_POS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_prev_q  <= 1'b0;
      cfg_o       <= '0;
      frame_err_o <= 1'b0;
      rsvd_err_o  <= 1'b0;
    end else begin
      upd_prev_q <= upd_i;
      if (upd_rise_o) begin
        frame_err_o <= (cnt_i != CNT_W'(WORD_BITS));
        rsvd_err_o  <= word_i[RSVD_POS];
        if (!word_i[RSVD_POS]) cfg_o <= decoded;
      end
    end
  end

  // R4: without a strobe the active settings hold
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_rise_o |=> $stable(cfg_o));
  // R8: a reserved-bit violation leaves the settings untouched
  a_r8_rsvd_block: assert property (@(posedge clk) disable iff (!rst_n)
    upd_rise_o && word_i[RSVD_POS] |=> $stable(cfg_o) && rsvd_err_o);
  // R9: flags change only at a strobe
  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_rise_o |=> $stable(frame_err_o) && $stable(rsvd_err_o));
endmodule

// File: rtl/dds_cfg_rx.sv
module dds_cfg_rx
  import dds_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sdata_i,
  input  logic                  bclk_i,
  input  logic                  upd_i,
  output logic [FREQ_BITS-1:0]  freq_o,
  output logic [PHASE_BITS-1:0] phase_o,
  output logic                  mult_en_o,
  output logic                  pwr_down_o,
  output logic                  frame_err_o,
  output logic                  rsvd_err_o
);
  logic [2:0]           sync_lvl;
  logic [WORD_BITS-1:0] staged;
  logic [CNT_W-1:0]     bit_cnt;
  logic                 upd_rise;
  dds_cfg_t             active;

  sync_chain #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({upd_i, bclk_i, sdata_i}),
    .sync_o  (sync_lvl)
  );

  ser_shifter #(.NBITS(WORD_BITS)) i_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_i  (sync_lvl[0]),
    .bclk_i (sync_lvl[1]),
    .clr_i  (upd_rise),
    .word_o (staged),
    .cnt_o  (bit_cnt)
  );

  cfg_latch i_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_i       (sync_lvl[2]),
    .word_i      (staged),
    .cnt_i       (bit_cnt),
    .upd_rise_o  (upd_rise),
    .cfg_o       (active),
    .frame_err_o (frame_err_o),
    .rsvd_err_o  (rsvd_err_o)
  );

  assign freq_o     = active.freq;
  assign phase_o    = active.phase;
  assign mult_en_o  = active.mult_en;
  assign pwr_down_o = active.pwr_down;

  // R5: a clean strobe lands the staged tuning word on the outputs
  a_r5_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    upd_rise && !staged[RSVD_POS] |=> freq_o == $past(staged[FREQ_BITS-1:0]));
endmodule

// File: tb/test_dds_cfg_rx.sv
module test_dds_cfg_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdata = 1'b0;
  logic        bclk = 1'b0;
  logic        upd = 1'b0;
  logic [31:0] freq;
  logic [4:0]  phase;
  logic        mult_en, pwr_down, frame_err, rsvd_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dds_cfg_rx i_dds_cfg_rx (
    .clk(clk), .rst_n(rst_n), .sdata_i(sdata), .bclk_i(bclk), .upd_i(upd),
    .freq_o(freq), .phase_o(phase), .mult_en_o(mult_en), .pwr_down_o(pwr_down),
    .frame_err_o(frame_err), .rsvd_err_o(rsvd_err)
  );

  localparam logic [39:0] VECS [5] = '{
    40'h00_0000_0001, 40'hF8_FFFF_FFFF, 40'h45_1234_5678,
    40'hA9_8765_4321, 40'h04_DEAD_BEEF
  };

  logic [39:0] model_sr = '0;
  logic [39:0] exp_act  = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_bits(input logic [39:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      sdata = w[i];
      bclk  = 1'b0;
      wait_clk(4);
      bclk  = 1'b1;
      wait_clk(4);
      model_sr = {w[i], model_sr[39:1]};
    end
    bclk = 1'b0;
    wait_clk(4);
  endtask

  task automatic strobe();
    upd = 1'b1;
    wait_clk(4);
    upd = 1'b0;
    wait_clk(4);
  endtask

  task automatic chk_fields(input string req, input logic [39:0] w);
    chk(req, freq, w[31:0]);
    chk(req, phase, w[39:35]);
    chk(req, mult_en, w[32]);
    chk(req, pwr_down, w[34]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    // R1: reset state
    chk("R1", {freq, phase, mult_en, pwr_down, frame_err, rsvd_err}, '0);
    rst_n = 1'b1;
    wait_clk(3);

    // Table walk: R2, R3, R4, R5
    for (int v = 0; v < 5; v++) begin
      send_bits(VECS[v], 40);
      chk_fields("R4", exp_act);
      strobe();
      exp_act = VECS[v];
      chk_fields("R3", exp_act);
      chk("R5", {frame_err, rsvd_err}, 2'b00);
    end

    // R6: shifting during power-down, then exit
    chk("R6", pwr_down, 1'b1);
    send_bits(40'h00_0000_ABCD, 40);
    chk("R6", pwr_down, 1'b1);
    strobe();
    exp_act = 40'h00_0000_ABCD;
    chk("R6", pwr_down, 1'b0);
    chk("R6", freq, 32'h0000_ABCD);

    // R8: reserved bit set blocks the transfer
    send_bits(40'h02_1111_1111, 40);
    strobe();
    chk("R8", rsvd_err, 1'b1);
    chk("R8", frame_err, 1'b0);
    chk_fields("R8", exp_act);

    // R9: clean strobe clears flags
    send_bits(VECS[0], 40);
    strobe();
    exp_act = VECS[0];
    chk("R9", {frame_err, rsvd_err}, 2'b00);
    chk_fields("R9", exp_act);

    // R7: short frame still transfers, with frame error
    send_bits(40'h00_0000_00A5, 8);
    strobe();
    exp_act = model_sr;
    chk("R7", frame_err, 1'b1);
    chk_fields("R7", exp_act);

    // R7: strobe with no new bits
    send_bits(40'h0, 40);
    strobe();
    chk("R7", frame_err, 1'b0);
    strobe();
    chk("R7", frame_err, 1'b1);

    // R10: overlong frame keeps the last 40 bits
    send_bits(40'h1, 1);
    send_bits(VECS[3], 40);
    strobe();
    exp_act = VECS[3];
    chk("R10", frame_err, 1'b1);
    chk_fields("R10", exp_act);

    // R9: clean frame after an error
    send_bits(VECS[1], 40);
    strobe();
    chk("R9", frame_err, 1'b0);
    chk_fields("R9", VECS[1]);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule